// File: doc/BRIEF.md
# Nibble-Serial Byte Arithmetic Unit

This block computes byte-wide add, subtract and increment results using a single 4-bit adder that is used twice per operation. A start strobe captures the first operand, the operation code, the carry-in and the destination kind. On the next clock the second operand is captured from its own bus. The low nibble is then computed and held in a low-result latch, together with the carry (or borrow) out of that pass. The high nibble is computed in the following arithmetic state. In that same state the full byte, the carry flag and the zero flag are presented with a one-cycle write enable for the register file.

When the destination is a register, the two arithmetic states only advance on a step strobe. The surrounding sequencer pulses step during the first two states of the next opcode fetch, so the write-back overlaps that fetch. When the destination is memory, no overlap is allowed. The two arithmetic states then run back to back right after the operands are captured, with no step needed, so the write is finished before the next fetch.

Top module: `nibble_alu8`

## Requirements
- R1: After reset, `busy` and `wr_en` are 0.
- R2: `a_in` is captured on the clock edge where `start` is high. `b_in` is captured on the following edge. Operand values at other edges have no effect on the result.
- R3: `op_sel` 2'b00 (ADD) yields `result` = (op1 + op2 + `carry_in`) mod 256, with `carry_f` equal to bit 8 of that sum.
- R4: `op_sel` 2'b01 (SUB) yields `result` = (op1 - op2 - `carry_in`) mod 256, with `carry_f` = 1 exactly when that difference is negative (borrow).
- R5: `op_sel` 2'b10 or 2'b11 (INC) yields op1 + 1 mod 256, with `carry_f` = 1 only for op1 = 8'hFF. op2 and `carry_in` have no effect.
- R6: A carry or borrow out of the low nibble reaches the high nibble (for example, 8'h0F + 8'h01 = 8'h10).
- R7: With `dest_mem` = 0, the low pass advances only on an edge with `step` high. `wr_en` is high only in the high-nibble state during a cycle with `step` high. Without step, the unit stays busy and does not write.
- R8: With `dest_mem` = 1, `wr_en` is high in the third cycle after the `start` edge, whatever `step` does.
- R9: `zero_f` is 1 during the write exactly when the 8-bit result is zero.
- R10: `busy` rises on the `start` edge and falls on the edge that ends the write cycle. A `start` while busy is ignored.
- R11: `wr_en` lasts exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; captures op1, op code, carry-in and destination kind |
| step | input | 1 | Advance strobe for the arithmetic states when the destination is a register |
| op_sel | input | 2 | 00 ADD, 01 SUB, 1x INC |
| carry_in | input | 1 | Carry for ADD, borrow for SUB |
| dest_mem | input | 1 | 1: memory destination, no overlap; 0: register destination |
| a_in | input | 8 | First operand bus |
| b_in | input | 8 | Second operand bus |
| result | output | 8 | Byte result, valid while wr_en is high |
| wr_en | output | 1 | Register-file write strobe |
| carry_f | output | 1 | Carry (ADD/INC) or borrow (SUB) flag, valid with wr_en |
| zero_f | output | 1 | Zero flag, valid with wr_en |
| busy | output | 1 | Operation in progress |

## Verification
The bench targets nibble-boundary carries and borrows (0x0F+0x01, 0x50-0x21, 0x00-0x01). A unit that dropped the held nibble carry would return a high nibble off by one. It covers increment with a nonzero second operand and carry-in, which a design that failed to mask them would fold into the sum. Register-destination runs hold step low for several cycles, including between the two passes. A design that advanced without step would write early. Memory-destination runs check the write lands exactly three cycles after start. A start pulse injected while busy must neither corrupt the running result nor cause a second write.

// File: rtl/nibble_alu8.sv
module nibble_alu8 #(
  parameter int NIB = 4,
  localparam int W = 2 * NIB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         step,
  input  logic [1:0]   op_sel,
  input  logic         carry_in,
  input  logic         dest_mem,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         wr_en,
  output logic         carry_f,
  output logic         zero_f,
  output logic         busy
);

  typedef enum logic [1:0] {S_IDLE, S_OP2, S_LO, S_HI} state_t;
  state_t state;

  logic [W-1:0]   op1_q, op2_q;
  logic [1:0]     sel_q;
  logic           cin_q, mem_q, nc_q;
  logic [NIB-1:0] lo_q;

  logic           is_inc, is_sub, adv, hi_ph;
  logic [NIB-1:0] x_nib, y_raw, y_nib;
  logic           c_pass;
  logic [NIB:0]   sum;

  assign is_inc = sel_q[1];
  assign is_sub = (sel_q == 2'b01);
  assign adv    = mem_q | step;
  assign hi_ph  = (state == S_HI);

  assign x_nib  = hi_ph ? op1_q[W-1:NIB] : op1_q[NIB-1:0];
  assign y_raw  = is_inc ? '0 : (hi_ph ? op2_q[W-1:NIB] : op2_q[NIB-1:0]);
  assign y_nib  = is_sub ? ~y_raw : y_raw;
  assign c_pass = hi_ph ? nc_q : (is_inc ? 1'b1 : (is_sub ? ~cin_q : cin_q));
  assign sum    = {1'b0, x_nib} + {1'b0, y_nib} + {{NIB{1'b0}}, c_pass};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op1_q <= '0;
      op2_q <= '0;
      sel_q <= '0;
      cin_q <= 1'b0;
      mem_q <= 1'b0;
      nc_q  <= 1'b0;
      lo_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          op1_q <= a_in;
          sel_q <= op_sel;
          cin_q <= carry_in;
          mem_q <= dest_mem;
          state <= S_OP2;
        end
        S_OP2: begin
          op2_q <= b_in;
          state <= S_LO;
        end
        S_LO: if (adv) begin
          lo_q  <= sum[NIB-1:0];
          nc_q  <= sum[NIB];
          state <= S_HI;
        end
        S_HI: if (adv) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign wr_en   = hi_ph & adv;
  assign result  = {sum[NIB-1:0], lo_q};
  assign carry_f = is_sub ? ~sum[NIB] : sum[NIB];
  assign zero_f  = (sum[NIB-1:0] == '0) && (lo_q == '0);
  assign busy    = (state != S_IDLE);

endmodule

module nibble_alu8_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic step,
  input logic mem_q,
  input logic wr_en,
  input logic busy
);

  assert_wr_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_wr_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en) |=> busy);

  assert_idle_after_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !busy);

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_reg_needs_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mem_q) |-> step);

endmodule

bind nibble_alu8 nibble_alu8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .step(step),
  .mem_q(mem_q), .wr_en(wr_en), .busy(busy)
);

// File: tb/test_nibble_alu8.sv
module test_nibble_alu8;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, step = 1'b0, carry_in = 1'b0, dest_mem = 1'b0;
  logic [1:0] op_sel = 2'b00;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] result;
  logic       wr_en, carry_f, zero_f, busy;

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  nibble_alu8 i_nibble_alu8 (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .op_sel(op_sel),
    .carry_in(carry_in), .dest_mem(dest_mem), .a_in(a_in), .b_in(b_in),
    .result(result), .wr_en(wr_en), .carry_f(carry_f), .zero_f(zero_f), .busy(busy)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [1:0] sel, input logic cin);
    int r;
    logic [7:0] res;
    logic c;
    if (sel[1]) begin
      r = int'(a) + 1;
      res = r[7:0]; c = (a == 8'hFF);
    end else if (sel == 2'b01) begin
      r = int'(a) - int'(b) - int'(cin);
      res = r[7:0]; c = (r < 0);
    end else begin
      r = int'(a) + int'(b) + int'(cin);
      res = r[7:0]; c = r[8];
    end
    return {res, c, (res == 8'h00)};
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (rst_n && wr_en) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R10/R11: unexpected write actual %h expected none", result);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {result, carry_f, zero_f}, e);
        end
      end
    end
  end

  task automatic do_op(input logic [7:0] a, input logic [7:0] b, input logic [1:0] sel,
                       input logic cin, input logic mem, input int gap, input int gap2,
                       input bit inj, input string tag);
    exp_q.push_back(model(a, b, sel, cin));
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b1; a_in = a; b_in = ~b; op_sel = sel; carry_in = cin; dest_mem = mem;
    @(negedge clk);
    start = 1'b0; a_in = ~a; b_in = b; op_sel = ~sel; carry_in = ~cin; dest_mem = ~mem;
    #(PERIOD/4);
    check("R10 busy after start", {9'b0, busy}, 10'd1);
    if (mem) begin
      @(negedge clk); b_in = ~b; step = 1'b0;
      #(PERIOD/4);
      check("R8 no write in low pass", {9'b0, wr_en}, 10'd0);
      @(negedge clk);
      #(PERIOD/4);
      check("R8 write third cycle", {9'b0, wr_en}, 10'd1);
    end else begin
      for (int i = 0; i < gap; i++) begin
        @(negedge clk); b_in = ~b;
        start = inj && (i == 0);
        a_in = 8'h99;
        #(PERIOD/4);
        check("R7 wait low step", {8'b0, busy, wr_en}, 10'b10);
      end
      @(negedge clk); start = 1'b0; b_in = ~b; step = 1'b1;
      @(negedge clk); step = 1'b0;
      for (int i = 0; i < gap2; i++) begin
        #(PERIOD/4);
        check("R7 wait high step", {8'b0, busy, wr_en}, 10'b10);
        @(negedge clk);
      end
      step = 1'b1;
      #(PERIOD/4);
      check("R7 write on step", {9'b0, wr_en}, 10'd1);
    end
    @(negedge clk); step = 1'b0;
    #(PERIOD/4);
    check("R10/R11 idle after write", {8'b0, busy, wr_en}, 10'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 1);
    check("R1 reset", {8'b0, busy, wr_en}, 10'd0);
    rst_n = 1'b1;
    do_op(8'h3A, 8'h25, 2'b00, 1'b0, 1'b0, 2, 1, 1'b0, "R2/R3 add");
    do_op(8'h0F, 8'h01, 2'b00, 1'b0, 1'b1, 0, 0, 1'b0, "R6 nibble carry");
    do_op(8'hF0, 8'h10, 2'b00, 1'b0, 1'b0, 0, 0, 1'b0, "R3/R9 add wrap zero");
    do_op(8'hFF, 8'h00, 2'b00, 1'b1, 1'b0, 3, 2, 1'b0, "R6 carry-in ripple");
    do_op(8'h50, 8'h21, 2'b01, 1'b0, 1'b1, 0, 0, 1'b0, "R4/R6 sub nibble borrow");
    do_op(8'h00, 8'h01, 2'b01, 1'b0, 1'b0, 1, 0, 1'b0, "R4 sub underflow");
    do_op(8'h05, 8'h03, 2'b01, 1'b1, 1'b1, 0, 0, 1'b0, "R4 sub borrow-in");
    do_op(8'h42, 8'h42, 2'b01, 1'b0, 1'b0, 0, 1, 1'b0, "R9 sub zero");
    do_op(8'h7F, 8'h55, 2'b10, 1'b1, 1'b0, 1, 0, 1'b0, "R5 inc ignores op2");
    do_op(8'hFF, 8'hAA, 2'b11, 1'b0, 1'b1, 0, 0, 1'b0, "R5 inc wrap");
    do_op(8'h12, 8'h34, 2'b00, 1'b1, 1'b0, 3, 1, 1'b1, "R10 start ignored while busy");
    repeat (4) @(negedge clk);
    #(PERIOD/4);
    check("R10 no extra op", {8'b0, busy, wr_en}, 10'd0);
    check("R11 all writes seen", 10'(exp_q.size()), 10'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule